// File: doc/BRIEF.md
# Slew-Rate Calibration Sequencer

This block runs one transmitter slew-rate calibration for a selected port of a multi-port transceiver. A single-cycle start pulse latches the port number. The block then switches on the port's ring oscillator and brings up the shared frequency meter in a fixed order: free-running clock first, then channel and cycle-count configuration, then the meter enable. It polls the meter's valid flag at a fixed interval for a bounded number of tries. When the flag is seen, or when the tries run out, it captures the measured count and takes the meter back down in reverse order.

The captured count is turned into a 3-bit slew code. The code is the rounded quotient of 1024 × 26 × 28 over the count times 1000. The division runs on a bit-serial restoring divider, so no wide combinational divider is needed. A code above 7 is clamped to 7. A count of zero is treated as a failed measurement, and the default code 4 is used instead. The code is presented with a one-cycle write strobe while the oscillator is still enabled. The oscillator is switched off on the next cycle, and a done pulse follows.

The sequence is strictly linear. States, in order: IDLE, OSC_ON, CLK_ON, CONFIG, MEASURE, WAIT, MTR_OFF, CLK_OFF, DIVIDE, WRITE, RELEASE, DONE.

Transitions:
- IDLE to OSC_ON on start.
- WAIT to MTR_OFF on a poll tick that sees valid, or on the last poll tick.
- CLK_OFF to DIVIDE when the count is nonzero, or to WRITE when it is zero.
- DIVIDE to WRITE when the divider finishes.
- DONE to IDLE.
- Every other state advances to the next one after one cycle.

Top module: `slew_cal_seq`

## Requirements
- R1: While reset is held, and right after it is released, ring_en, fm_frck_en, fm_en, code_wr and done are 0, and slew_code, fm_sel and fm_cycles are 0.
- R2: A start pulse in IDLE raises ring_en on the next cycle, before fm_frck_en and fm_en. While fm_en is high, ring_en and fm_frck_en are high, fm_sel equals the latched port index, and fm_cycles equals the cycle count 1024.
- R3: fm_frck_en stays high for as long as fm_en is high. Both are low by the time code_wr is asserted.
- R4: fm_valid is sampled once every POLL_GAP cycles while waiting. When it is seen high, the count is captured and fm_en falls. fm_en is high for exactly POLL_GAP+1 cycles if valid is already high when the meter is enabled.
- R5: If valid is never seen, the wait ends after POLL_TRIES samples (fm_en high for POLL_GAP×POLL_TRIES+1 cycles). The count is captured anyway and the sequence completes normally.
- R6: For a nonzero count N, slew_code = floor((745472 + 500·N) / (1000·N)), clamped to 7.
- R7: A captured count of zero gives slew_code = 4.
- R8: code_wr is a one-cycle pulse. During it, slew_code holds the new code and ring_en is still high. On the following cycle, ring_en is low.
- R9: done is a one-cycle pulse, issued while ring_en is low. The block then returns to IDLE.
- R10: A start pulse while a calibration is running is ignored. It changes neither fm_sel nor the outcome, and no second calibration follows.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low synchronous reset |
| start | input | 1 | Start pulse, accepted only in IDLE |
| port_idx | input | PORT_W | Port to calibrate, latched on an accepted start |
| ring_en | output | 1 | Ring-oscillator calibration enable |
| slew_code | output | 3 | Slew-rate control code |
| code_wr | output | 1 | One-cycle strobe to write slew_code into the port |
| fm_frck_en | output | 1 | Frequency-meter free-running clock enable |
| fm_en | output | 1 | Frequency-meter enable |
| fm_sel | output | PORT_W | Frequency-meter channel select |
| fm_cycles | output | CNT_W | Frequency-meter reference cycle count |
| fm_valid | input | 1 | Meter result valid |
| fm_count | input | FM_W | Meter result |
| done | output | 1 | One-cycle completion pulse |

## Verification
A corrupted state register or a wrong transition shows up at the ports within one cycle, because every output is decoded straight from the current state. Such a fault appears as a meter enable without the oscillator, a strobe with the oscillator already off, or a done pulse that lasts too long. Poll counter faults show up as a wrong number of fm_en cycles, measured to the exact cycle for both the early-valid case and the timeout case. Divider or rounding faults show up only at the write strobe, as a wrong slew code. For this reason the measured count is swept across every value where the rounded quotient changes, and across zero and the maximum count.

// File: rtl/slew_cal_pkg.sv
package slew_cal_pkg;
    localparam int REF_MHZ  = 26;
    localparam int COEF     = 28;
    localparam int SCALE    = 1000;
    localparam int CODE_W   = 3;
    localparam int DEF_CODE = 4;
    localparam int CODE_MAX = 7;

    typedef enum logic [3:0] {
        S_IDLE, S_OSC_ON, S_CLK_ON, S_CONFIG, S_MEASURE, S_WAIT,
        S_MTR_OFF, S_CLK_OFF, S_DIVIDE, S_WRITE, S_RELEASE, S_DONE
    } cal_state_e;
endpackage

// File: rtl/slew_cal_poll.sv
module slew_cal_poll #(
    parameter int GAP   = 1250,
    parameter int TRIES = 20
) (
    input  logic clk,
    input  logic rst_n,
    input  logic run,
    output logic tick,
    output logic last
);
    localparam int GW = $clog2(GAP + 1);
    localparam int TW = $clog2(TRIES + 1);

    logic [GW-1:0] gap_q;
    logic [TW-1:0] try_q;

    assign tick = run && (gap_q == GW'(GAP - 1));
    assign last = tick && (try_q == TW'(TRIES - 1));

    always_ff @(posedge clk) begin
        if (!rst_n || !run) begin
            gap_q <= '0;
            try_q <= '0;
        end else if (tick) begin
            gap_q <= '0;
            try_q <= try_q + 1'b1;
        end else begin
            gap_q <= gap_q + 1'b1;
        end
    end
endmodule

// File: rtl/slew_cal_div.sv
module slew_cal_div #(
    parameter int DVD_W = 27,
    parameter int DVS_W = 26
) (
    input  logic             clk,
    input  logic             rst_n,
    input  logic             go,
    input  logic [DVD_W-1:0] dividend,
    input  logic [DVS_W-1:0] divisor,
    output logic [DVD_W-1:0] quo,
    output logic             fin
);
    localparam int CW = $clog2(DVD_W + 1);

    logic [DVS_W-1:0] rem_q;
    logic [DVS_W-1:0] dvs_q;
    logic [CW-1:0]    cnt_q;
    logic [DVS_W:0]   shifted;
    logic [DVS_W:0]   diff;
    logic             fits;

    assign shifted = {rem_q, quo[DVD_W-1]};
    assign diff    = shifted - {1'b0, dvs_q};
    assign fits    = shifted >= {1'b0, dvs_q};

    always_ff @(posedge clk) begin
        if (!rst_n) begin
            rem_q <= '0;
            dvs_q <= '0;
            cnt_q <= '0;
            quo   <= '0;
            fin   <= 1'b0;
        end else if (go) begin
            rem_q <= '0;
            dvs_q <= divisor;
            quo   <= dividend;
            cnt_q <= CW'(DVD_W);
            fin   <= 1'b0;
        end else if (cnt_q != '0) begin
            rem_q <= fits ? diff[DVS_W-1:0] : shifted[DVS_W-1:0];
            quo   <= {quo[DVD_W-2:0], fits};
            cnt_q <= cnt_q - 1'b1;
            fin   <= (cnt_q == CW'(1));
        end else begin
            fin   <= 1'b0;
        end
    end
endmodule

// File: rtl/slew_cal_seq.sv
module slew_cal_seq
    import slew_cal_pkg::*;
#(
    parameter int PORT_W     = 2,
    parameter int FM_W       = 16,
    parameter int CNT_W      = 24,
    parameter int CYCLES     = 1024,
    parameter int POLL_GAP   = 1250,
    parameter int POLL_TRIES = 20
) (
    input  logic              clk,
    input  logic              rst_n,
    input  logic              start,
    input  logic [PORT_W-1:0] port_idx,
    output logic              ring_en,
    output logic [2:0]        slew_code,
    output logic              code_wr,
    output logic              fm_frck_en,
    output logic              fm_en,
    output logic [PORT_W-1:0] fm_sel,
    output logic [CNT_W-1:0]  fm_cycles,
    input  logic              fm_valid,
    input  logic [FM_W-1:0]   fm_count,
    output logic              done
);
    localparam int NUM   = CYCLES * REF_MHZ * COEF;
    localparam int NUM_W = $clog2(NUM + 1);
    localparam int DVS_W = FM_W + $clog2(SCALE);
    localparam int DVD_W = ((DVS_W > NUM_W) ? DVS_W : NUM_W) + 1;
    localparam logic [DVD_W-1:0] NUM_V = DVD_W'(NUM);
    localparam logic [DVD_W-1:0] MAXQ  = DVD_W'(CODE_MAX);

    cal_state_e state_q, state_d;

    logic [PORT_W-1:0] port_q;
    logic [FM_W-1:0]   fm_q;
    logic [2:0]        code_q;
    logic              tick, last, div_go, div_fin;
    logic [DVS_W-1:0]  den;
    logic [DVD_W-1:0]  dvd, quo;

    assign den    = DVS_W'(fm_q) * DVS_W'(SCALE);
    assign dvd    = NUM_V + DVD_W'(den >> 1);
    assign div_go = (state_q == S_CLK_OFF) && (fm_q != '0);

    slew_cal_poll #(.GAP(POLL_GAP), .TRIES(POLL_TRIES)) u_poll (
        .clk(clk), .rst_n(rst_n), .run(state_q == S_WAIT),
        .tick(tick), .last(last)
    );

    slew_cal_div #(.DVD_W(DVD_W), .DVS_W(DVS_W)) u_div (
        .clk(clk), .rst_n(rst_n), .go(div_go),
        .dividend(dvd), .divisor(den), .quo(quo), .fin(div_fin)
    );

    // state register
    always_ff @(posedge clk) begin
        if (!rst_n) state_q <= S_IDLE;
        else        state_q <= state_d;
    end

    // next state
    always_comb begin
        state_d = state_q;
        unique case (state_q)
            S_IDLE:    if (start) state_d = S_OSC_ON;
            S_OSC_ON:  state_d = S_CLK_ON;
            S_CLK_ON:  state_d = S_CONFIG;
            S_CONFIG:  state_d = S_MEASURE;
            S_MEASURE: state_d = S_WAIT;
            S_WAIT:    if (tick && (fm_valid || last)) state_d = S_MTR_OFF;
            S_MTR_OFF: state_d = S_CLK_OFF;
            S_CLK_OFF: state_d = (fm_q == '0) ? S_WRITE : S_DIVIDE;
            S_DIVIDE:  if (div_fin) state_d = S_WRITE;
            S_WRITE:   state_d = S_RELEASE;
            S_RELEASE: state_d = S_DONE;
            S_DONE:    state_d = S_IDLE;
            default:   state_d = S_IDLE;
        endcase
    end

    // captured data
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            port_q <= '0;
            fm_q   <= '0;
            code_q <= '0;
        end else begin
            if (state_q == S_IDLE && start)
                port_q <= port_idx;
            if (state_q == S_WAIT && tick && (fm_valid || last))
                fm_q <= fm_count;
            if (state_q == S_CLK_OFF && fm_q == '0)
                code_q <= 3'(DEF_CODE);
            if (state_q == S_DIVIDE && div_fin)
                code_q <= (quo > MAXQ) ? 3'(CODE_MAX) : quo[2:0];
        end
    end

    // outputs
    always_comb begin
        ring_en    = 1'b0;
        fm_frck_en = 1'b0;
        fm_en      = 1'b0;
        fm_cycles  = '0;
        code_wr    = 1'b0;
        done       = 1'b0;
        unique case (state_q)
            S_OSC_ON:  ring_en = 1'b1;
            S_CLK_ON:  begin ring_en = 1'b1; fm_frck_en = 1'b1; end
            S_CONFIG:  begin ring_en = 1'b1; fm_frck_en = 1'b1; fm_cycles = CNT_W'(CYCLES); end
            S_MEASURE, S_WAIT: begin
                ring_en = 1'b1; fm_frck_en = 1'b1; fm_en = 1'b1; fm_cycles = CNT_W'(CYCLES);
            end
            S_MTR_OFF: begin ring_en = 1'b1; fm_frck_en = 1'b1; fm_cycles = CNT_W'(CYCLES); end
            S_CLK_OFF, S_DIVIDE: ring_en = 1'b1;
            S_WRITE:   begin ring_en = 1'b1; code_wr = 1'b1; end
            S_DONE:    done = 1'b1;
            default:   ;
        endcase
    end

    assign fm_sel    = port_q;
    assign slew_code = code_q;
endmodule

// File: rtl/slew_cal_chk.sv
module slew_cal_chk #(
    parameter int PORT_W = 2
) (
    input logic              clk,
    input logic              rst_n,
    input logic              ring_en,
    input logic              code_wr,
    input logic              fm_frck_en,
    input logic              fm_en,
    input logic [PORT_W-1:0] fm_sel,
    input logic              done
);
    a_r2_meter_needs_osc: assert property (@(posedge clk) disable iff (!rst_n)
        fm_en |-> ring_en);
    a_r3_meter_needs_clock: assert property (@(posedge clk) disable iff (!rst_n)
        fm_en |-> fm_frck_en);
    a_r8_release_after_write: assert property (@(posedge clk) disable iff (!rst_n)
        code_wr |=> (!code_wr && !ring_en));
    a_r8_write_with_osc: assert property (@(posedge clk) disable iff (!rst_n)
        code_wr |-> ring_en);
    a_r9_done_single: assert property (@(posedge clk) disable iff (!rst_n)
        done |=> !done);
    a_r9_done_osc_off: assert property (@(posedge clk) disable iff (!rst_n)
        done |-> (!ring_en && !fm_en));
    a_r10_channel_held: assert property (@(posedge clk) disable iff (!rst_n)
        (fm_en && $past(fm_en)) |-> $stable(fm_sel));
endmodule

bind slew_cal_seq slew_cal_chk #(.PORT_W(PORT_W)) u_chk (
    .clk(clk), .rst_n(rst_n), .ring_en(ring_en), .code_wr(code_wr),
    .fm_frck_en(fm_frck_en), .fm_en(fm_en), .fm_sel(fm_sel), .done(done)
);

// File: tb/sim_slew_cal_seq.sv
module sim_slew_cal_seq;
    localparam int GAP   = 4;
    localparam int TRIES = 5;

    logic        clk = 1'b0;
    logic        rst_n = 1'b0;
    logic        start = 1'b0;
    logic [1:0]  port_idx = '0;
    logic        ring_en, code_wr, fm_frck_en, fm_en, done;
    logic [2:0]  slew_code;
    logic [1:0]  fm_sel;
    logic [23:0] fm_cycles;
    logic        fm_valid = 1'b0;
    logic [15:0] fm_count = '0;

    int total = 0;
    int bad = 0;

    always #4 clk = ~clk;

    slew_cal_seq #(.POLL_GAP(GAP), .POLL_TRIES(TRIES)) u0 (
        .clk(clk), .rst_n(rst_n), .start(start), .port_idx(port_idx),
        .ring_en(ring_en), .slew_code(slew_code), .code_wr(code_wr),
        .fm_frck_en(fm_frck_en), .fm_en(fm_en), .fm_sel(fm_sel),
        .fm_cycles(fm_cycles), .fm_valid(fm_valid), .fm_count(fm_count),
        .done(done)
    );

    task automatic check(bit ok, string req, longint act, longint exp);
        total++;
        if (!ok) begin
            bad++;
            $display("FAIL %s actual=%0d expected=%0d", req, act, exp);
        end
    endtask

    function automatic int exp_code(int n);
        int q;
        if (n == 0) return 4;
        q = (745472 + n * 500) / (n * 1000);
        return (q > 7) ? 7 : q;
    endfunction

    task automatic run_cal(int port, int n, bit respond, bit poke);
        int  en_cnt = 0;
        bit  seen_en = 0;
        bit  seen_wr = 0;
        bit  seen_done = 0;
        int  ring_cnt = 0;
        int  exp_en = respond ? GAP + 1 : GAP * TRIES + 1;
        @(negedge clk);
        start = 1'b1; port_idx = 2'(port); fm_count = 16'(n);
        @(negedge clk);
        start = 1'b0;
        check(ring_en && !fm_frck_en && !fm_en, "R2 osc first", ring_en, 1);
        for (int g = 0; g < 600 && !seen_done; g++) begin
            start = 1'b0;
            if (fm_en) begin
                if (!seen_en) begin
                    seen_en = 1;
                    check(ring_en && fm_frck_en, "R2 osc and clock with meter", {ring_en, fm_frck_en}, 3);
                    check(fm_sel == 2'(port), "R2 channel select", fm_sel, port);
                    check(fm_cycles == 24'd1024, "R2 cycle count", fm_cycles, 1024);
                    fm_valid = respond;
                    if (poke) begin start = 1'b1; port_idx = 2'(port ^ 1); end
                end
                en_cnt++;
            end
            if (code_wr) begin
                seen_wr = 1;
                if (n == 0) check(slew_code == 3'(exp_code(n)), "R7 default code", slew_code, 4);
                else        check(slew_code == 3'(exp_code(n)), "R6 computed code", slew_code, exp_code(n));
                check(ring_en, "R8 osc on at write", ring_en, 1);
                check(!fm_en && !fm_frck_en, "R3 meter down before write", {fm_en, fm_frck_en}, 0);
                check(fm_sel == 2'(port), "R10 channel kept", fm_sel, port);
                if (respond) check(en_cnt == exp_en, "R4 poll interval", en_cnt, exp_en);
                else         check(en_cnt == exp_en, "R5 timeout length", en_cnt, exp_en);
                @(negedge clk);
                check(!code_wr && !ring_en, "R8 strobe single and osc off", {code_wr, ring_en}, 0);
            end
            if (done) begin
                check(!ring_en, "R9 osc off at done", ring_en, 0);
                @(negedge clk);
                check(!done, "R9 done single", done, 0);
                seen_done = 1;
            end else begin
                @(negedge clk);
            end
        end
        fm_valid = 1'b0;
        check(seen_done && seen_wr, "R9 sequence completes", {seen_wr, seen_done}, 3);
        if (poke) begin
            for (int k = 0; k < 80; k++) begin
                if (ring_en) ring_cnt++;
                @(negedge clk);
            end
            check(ring_cnt == 0, "R10 no second run", ring_cnt, 0);
        end
    endtask

    initial begin
        #1600000;
        bad++;
        total++;
        $display("FAIL watchdog actual=hung expected=finished");
        $display("test done: total=%0d bad=%0d", total, bad);
        $finish;
    end

    initial begin
        repeat (3) @(negedge clk);
        check(!ring_en && !fm_en && !fm_frck_en && !code_wr && !done, "R1 reset outputs", ring_en, 0);
        rst_n = 1'b1;
        @(negedge clk);
        check(!ring_en && !fm_en && !fm_frck_en && !code_wr && !done &&
              slew_code == 0 && fm_sel == 0 && fm_cycles == 0, "R1 after reset", slew_code, 0);

        // R7: zero count with valid; R5: timeouts with zero and nonzero counts
        run_cal(1, 0, 1'b1, 1'b0);
        run_cal(2, 0, 1'b0, 1'b0);
        run_cal(3, 300, 1'b0, 1'b0);
        // R10: start during measurement ignored
        run_cal(0, 150, 1'b1, 1'b1);
        // R6: extremes and rounding boundaries
        run_cal(1, 65535, 1'b1, 1'b0);
        run_cal(2, 1490, 1'b1, 1'b0);
        run_cal(3, 1491, 1'b1, 1'b0);
        // R6: sweep across every code transition
        for (int n = 1; n <= 1600; n++)
            run_cal(n % 4, n, 1'b1, 1'b0);

        $display("test done: total=%0d bad=%0d", total, bad);
        $finish;
    end
endmodule